// File: doc/BRIEF.md
# Startup-Mode PRG Address Decoder

This block decodes the CPU address bus of a cartridge into chip enables for three targets: a sequential boot device, a command/operand coprocessor port, and a bank-switched PRG-RAM of up to 16 banks of 8 KB. After reset it is in startup mode. In that mode every access to the upper half of the address space goes to the boot device. The boot device feeds the CPU a fixed stream of instructions that copy a loader into RAM. The loader fills PRG-RAM banks through the bankable $6000-$7FFF window. It then writes a control register once to leave startup mode. From then on, $8000-$FFFF is served from PRG-RAM, and the top 8 KB is hardwired to the last bank, which holds the vectors.

The enables and the bank lines are combinational functions of the current address, M2 and the mapper state. The mapper state (the startup flag and four bank registers) is sampled on a system clock. A register changes at the first clock edge that sees a qualified write cycle, which is M2 high with R/W low. There is no streaming data path, so the pins are plain control lines with no handshake.

Top module: `prg_boot_decoder`

## Requirements
- R1: After reset the block is in startup mode. With M2 high, any address with A15=1 asserts `boot_sel` and leaves `ram_ce` and `copro_sel` low.
- R2: While `cpu_m2` is low, `boot_sel`, `copro_sel` and `ram_ce` are all low, whatever the address is.
- R3: A write cycle to $5100 with data bit 0 = 1 leaves startup mode from the next clock edge onward. A write there with bit 0 = 0 has no effect while in startup mode.
- R4: Once startup mode has been left, only reset brings it back. A later write of 0 to $5100 keeps normal mode.
- R5: In normal mode, with M2 high, addresses $8000-$9FFF, $A000-$BFFF and $C000-$DFFF assert `ram_ce`. In these ranges `ram_bank` equals the bank register at $5105, $5106 and $5107 respectively.
- R6: In normal mode, $E000-$FFFF asserts `ram_ce` with `ram_bank` fixed at the last bank (15).
- R7: In both modes, $6000-$7FFF asserts `ram_ce` with `ram_bank` equal to the window register at $5104.
- R8: `copro_sel` is asserted only for $5000 and $5001, only in normal mode, and only with M2 high.
- R9: A write cycle to $5104-$5107 loads data bits 3:0 into that bank register. A read cycle at those addresses leaves the register unchanged. All four registers reset to 0.
- R10: No enable is asserted for any other address, and at most one enable is high at a time. `ram_bank` reads 0 whenever `ram_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples bus write cycles |
| rst_n | input | 1 | Active-low reset, returns to startup mode |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_m2 | input | 1 | CPU phase-2 clock, high in the data half of a cycle |
| cpu_data | input | 8 | CPU data bus, used for register writes |
| boot_sel | output | 1 | Boot device enable |
| copro_sel | output | 1 | Coprocessor port enable |
| ram_ce | output | 1 | PRG-RAM chip enable |
| ram_bank | output | 4 | PRG-RAM bank address lines (A16:A13) |

## Verification
The enables and bank lines have no register in their path. They are due in the same cycle as the address and M2 they depend on, so the bench compares them one time step after it drives each address. A register write takes effect at the single rising edge that sees the write cycle. Every mode or bank change is therefore checked only after the write strobe has been dropped at the next falling edge. The address sweeps then run against the updated expected state.

// File: rtl/prg_boot_pkg.sv
package prg_boot_pkg;
  // Address slots of 8 KB, taken from the top three address bits
  typedef enum logic [2:0] {
    SLOT_LOW0  = 3'd0,
    SLOT_LOW1  = 3'd1,
    SLOT_IO    = 3'd2,
    SLOT_WIN   = 3'd3,
    SLOT_8000  = 3'd4,
    SLOT_A000  = 3'd5,
    SLOT_C000  = 3'd6,
    SLOT_E000  = 3'd7
  } slot_e;

  // Indices into the bank register set
  localparam int unsigned BR_WIN  = 0;
  localparam int unsigned BR_8000 = 1;
  localparam int unsigned BR_A000 = 2;
  localparam int unsigned BR_C000 = 3;
  localparam int unsigned BR_NUM  = 4;
endpackage

// File: rtl/prg_boot_regs.sv
module prg_boot_regs
  import prg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h5100,
  parameter logic [ADDR_W-1:0] BREG_BASE = 16'h5104
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_stb,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               data,
  output logic                            startup,
  output logic [BR_NUM-1:0][BANK_W-1:0]   banks
);
  logic unused_hi;
  assign unused_hi = ^data[DATA_W-1:BANK_W];

  // Startup flag: set by reset, cleared once by a control write with bit 0 set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startup <= 1'b1;
    end else if (wr_stb && addr == CTRL_ADDR && data[0]) begin
      startup <= 1'b0;
    end
  end

  for (genvar g = 0; g < BR_NUM; g++) begin : g_breg
    localparam logic [ADDR_W-1:0] MY_ADDR = BREG_BASE + ADDR_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        banks[g] <= '0;
      end else if (wr_stb && addr == MY_ADDR) begin
        banks[g] <= data[BANK_W-1:0];
      end
    end
  end
endmodule

// File: rtl/prg_boot_map.sv
module prg_boot_map
  import prg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANK_W = 4,
  parameter logic [ADDR_W-1:0] COPRO_ADDR = 16'h5000
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          m2,
  input  logic                          startup,
  input  logic [BR_NUM-1:0][BANK_W-1:0] banks,
  output logic                          boot_sel,
  output logic                          copro_sel,
  output logic                          ram_ce,
  output logic [BANK_W-1:0]             ram_bank
);
  localparam logic [BANK_W-1:0] LAST_BANK = '1;

  slot_e slot;
  logic  copro_hit;
  logic  unused_a0;

  assign slot      = slot_e'(addr[ADDR_W-1 -: 3]);
  assign copro_hit = (addr[ADDR_W-1:1] == COPRO_ADDR[ADDR_W-1:1]);
  assign unused_a0 = addr[0];

  always_comb begin
    boot_sel  = 1'b0;
    copro_sel = 1'b0;
    ram_ce    = 1'b0;
    ram_bank  = '0;
    if (m2) begin
      unique case (slot)
        SLOT_IO:   copro_sel = copro_hit && !startup;
        SLOT_WIN: begin
          ram_ce   = 1'b1;
          ram_bank = banks[BR_WIN];
        end
        SLOT_8000, SLOT_A000, SLOT_C000, SLOT_E000: begin
          if (startup) begin
            boot_sel = 1'b1;
          end else begin
            ram_ce = 1'b1;
            case (slot)
              SLOT_8000: ram_bank = banks[BR_8000];
              SLOT_A000: ram_bank = banks[BR_A000];
              SLOT_C000: ram_bank = banks[BR_C000];
              default:   ram_bank = LAST_BANK;
            endcase
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prg_boot_decoder.sv
module prg_boot_decoder
  import prg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic [DATA_W-1:0] cpu_data,
  output logic              boot_sel,
  output logic              copro_sel,
  output logic              ram_ce,
  output logic [BANK_W-1:0] ram_bank
);
  logic                          wr_stb;
  logic                          startup;
  logic [BR_NUM-1:0][BANK_W-1:0] banks;

  assign wr_stb = cpu_m2 && !cpu_rw;

  prg_boot_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(cpu_addr),
    .data(cpu_data), .startup(startup), .banks(banks)
  );

  prg_boot_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_map (
    .addr(cpu_addr), .m2(cpu_m2), .startup(startup), .banks(banks),
    .boot_sel(boot_sel), .copro_sel(copro_sel), .ram_ce(ram_ce),
    .ram_bank(ram_bank)
  );
endmodule

// File: rtl/prg_boot_decoder_chk.sv
module prg_boot_decoder_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rw,
  input logic              cpu_m2,
  input logic [DATA_W-1:0] cpu_data,
  input logic              boot_sel,
  input logic              copro_sel,
  input logic              ram_ce,
  input logic [BANK_W-1:0] ram_bank
);
  logic left_boot;
  logic exit_wr;
  assign exit_wr = cpu_m2 && !cpu_rw && cpu_addr == 16'h5100 && cpu_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_boot <= 1'b0;
    else if (exit_wr) left_boot <= 1'b1;
  end

  AST_M2_GATES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_m2 |-> !(boot_sel || copro_sel || ram_ce)); // R2
  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({boot_sel, copro_sel, ram_ce})); // R10
  AST_BOOT_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel |-> cpu_addr[ADDR_W-1]); // R1
  AST_EXIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    exit_wr |=> !boot_sel); // R3
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    left_boot |-> !boot_sel); // R4
  AST_TOP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce && cpu_addr[ADDR_W-1 -: 3] == 3'b111) |-> ram_bank == '1); // R6
  AST_COPRO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    copro_sel |-> (cpu_addr[ADDR_W-1:1] == 15'h2800 && left_boot)); // R8
  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce |-> ram_bank == '0); // R10
endmodule

bind prg_boot_decoder prg_boot_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
  .cpu_m2(cpu_m2), .cpu_data(cpu_data), .boot_sel(boot_sel),
  .copro_sel(copro_sel), .ram_ce(ram_ce), .ram_bank(ram_bank)
);

// File: tb/prg_boot_decoder_tb.sv
`timescale 1ns/1ps
module prg_boot_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw = 1'b1;
  logic        cpu_m2 = 1'b0;
  logic [7:0]  cpu_data = '0;
  logic        boot_sel, copro_sel, ram_ce;
  logic [3:0]  ram_bank;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench-side model state
  bit       m_startup;
  bit [3:0] m_bank [4];

  always #4 clk = ~clk;

  prg_boot_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .cpu_data(cpu_data), .boot_sel(boot_sel),
    .copro_sel(copro_sel), .ram_ce(ram_ce), .ram_bank(ram_bank)
  );

  // Expected {boot, copro, ram, bank} from the requirements
  function automatic logic [6:0] expect_of(input logic [15:0] a, input bit m2);
    logic b, c, r;
    logic [3:0] k;
    b = 0; c = 0; r = 0; k = 0;
    if (m2) begin
      if (a >= 16'h6000 && a <= 16'h7FFF) begin r = 1; k = m_bank[0]; end     // R7
      else if (a[15] && m_startup) b = 1;                                      // R1
      else if (a[15]) begin
        r = 1;
        if (a < 16'hA000)      k = m_bank[1];                                   // R5
        else if (a < 16'hC000) k = m_bank[2];
        else if (a < 16'hE000) k = m_bank[3];
        else                   k = 4'hF;                                        // R6
      end
      else if ((a == 16'h5000 || a == 16'h5001) && !m_startup) c = 1;          // R8
    end
    return {b, c, r, k};
  endfunction

  task automatic check_at(input logic [15:0] a, input bit m2, input string req);
    logic [6:0] exp, act;
    @(negedge clk);
    cpu_addr = a; cpu_rw = 1'b1; cpu_m2 = m2; cpu_data = 8'hA5;
    #1;
    exp = expect_of(a, m2);
    act = {boot_sel, copro_sel, ram_ce, ram_bank};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h m2=%0d actual=%b expected=%b", req, a, m2, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; cpu_m2 = 1'b1;
    @(negedge clk);
    cpu_m2 = 1'b0; cpu_rw = 1'b1;
    if (a == 16'h5100 && d[0]) m_startup = 0;
    if (a >= 16'h5104 && a <= 16'h5107) m_bank[a - 16'h5104] = d[3:0];
  endtask

  task automatic sweep(input bit m2, input string req);
    for (int i = 0; i < 256; i++) check_at(16'(i) << 8, m2, req);
    for (int i = 0; i < 256; i++) check_at((16'(i) << 8) | 16'h00FF, m2, req);
    for (int i = 16'h4FFE; i <= 16'h5002; i++) check_at(16'(i), m2, req);
    for (int i = 16'h50FF; i <= 16'h5108; i++) check_at(16'(i), m2, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_startup = 1;
    for (int i = 0; i < 4; i++) m_bank[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R9 reset state, every 256-byte page
    sweep(1'b1, "R1");
    // R2 nothing with M2 low
    sweep(1'b0, "R2");
    // R7 R9 window bank loadable in startup
    bus_write(16'h5104, 8'hF9);
    check_at(16'h6000, 1, "R7"); check_at(16'h7FFF, 1, "R7");
    check_at(16'h8000, 1, "R1");
    // R3 bit0=0 ignored
    bus_write(16'h5100, 8'hFE);
    sweep(1'b1, "R3");
    // R9 bank registers written in startup, distinct values
    bus_write(16'h5105, 8'h03);
    bus_write(16'h5106, 8'h1C);
    bus_write(16'h5107, 8'h25);
    // R3 leave startup
    bus_write(16'h5100, 8'h01);
    sweep(1'b1, "R5");
    sweep(1'b0, "R2");
    // R9 read cycle at a register does not write it
    @(negedge clk);
    cpu_addr = 16'h5105; cpu_data = 8'h0E; cpu_rw = 1'b1; cpu_m2 = 1'b1;
    @(negedge clk);
    cpu_m2 = 1'b0;
    check_at(16'h8000, 1, "R9"); check_at(16'h9FFF, 1, "R9");
    // R4 writing 0 keeps normal mode
    bus_write(16'h5100, 8'h00);
    sweep(1'b1, "R4");
    // R5 R7 walk every bank value through each register
    for (int v = 0; v < 16; v++) begin
      for (int r = 0; r < 4; r++) bus_write(16'h5104 + 16'(r), 8'(v + 4*r));
      check_at(16'h6123, 1, "R7"); check_at(16'h8123, 1, "R5");
      check_at(16'hA123, 1, "R5"); check_at(16'hC123, 1, "R5");
      check_at(16'hFFFC, 1, "R6"); check_at(16'h5001, 1, "R8");
    end
    // R4 reset returns to startup
    @(negedge clk); rst_n = 1'b0;
    m_startup = 1;
    for (int i = 0; i < 4; i++) m_bank[i] = 0;
    @(negedge clk); rst_n = 1'b1;
    sweep(1'b1, "R4");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule